// File: doc/BRIEF.md
# Register-Mapped Byte Stack

This block holds a 512-deep stack of bytes that a host reaches through four 32-bit registers on a simple synchronous port. The data register feeds bytes in and hands them back. The control register fires push and pop by hand and reports status. The configuration register picks how pushes and pops are started. The pointer register exposes the stack pointer for direct reads and writes.

Push and pop each have their own mode. In automatic mode, a data-register access starts the operation. In manual mode, a control-register bit starts it. Manual pop has two read timings: the read can return the byte that a pop has already taken, or it can show the byte that the next pop will take. A written byte first goes to a write holding byte, and a popped byte goes to a read holding byte. Overflow and underflow are sticky flags, and each one is cleared by the opposite operation. An access that would go out of range is dropped.

Read data comes back one cycle after `rd_en`. A cycle that asserts `wr_en` ignores `rd_en`.

Top module: `byte_stack_regs`

## Requirements
- R1: Reset state:
  - the pointer is 0;
  - both sticky flags are clear;
  - the configuration is 0;
  - both holding bytes are 0.
- R2: Register offsets and the configuration register:
  - Offsets are: 0x0 data, 0x4 control, 0x8 configuration, 0xC pointer.
  - Configuration bit 0 is the push mode (1 automatic, 0 manual).
  - Configuration bit 1 is the pop mode (same encoding).
  - Configuration bit 2 is the manual pop timing (0 pop then read, 1 read then pop).
  - The configuration reads back with every other bit 0.
- R3: A data write stores the low byte of `wr_data` in the write holding byte.
  - In automatic push mode, the same write also pushes that byte.
  - In manual push mode, no push happens until control bit 0 is written as 1. The byte pushed is then the one held.
- R4: A push when the pointer is 0x200 or above:
  - sets the sticky overflow flag;
  - leaves the pointer and the array unchanged.
  Otherwise a push writes the byte at the pointer and increments the pointer. Every push clears the underflow flag.
- R5: A pop when the pointer is 0:
  - sets the sticky underflow flag;
  - changes nothing else.
  Otherwise a pop decrements the pointer and loads the cell at the new pointer into the read holding byte. Every pop clears the overflow flag.
- R6: In automatic pop mode, a data read first pops and then returns the read holding byte.
- R7: In manual pop-then-read mode, a data read returns the read holding byte and leaves the pointer unchanged.
- R8: In manual read-then-pop mode, a data read returns the cell just below the pointer, or the read holding byte when the pointer is 0.
- R9: Control register layout. The trigger bits 0 and 1 always read as 0. The status bits are:
  - bit 4: empty (pointer equals 0);
  - bit 5: full (pointer at or above 0x200);
  - bit 6: overflow;
  - bit 7: underflow.
- R10: The pointer register is readable and writable, and only its low 10 bits are kept. Array cell indices wrap modulo 0x200.
- R11: A control write with both trigger bits set pushes first and then pops, within the same cycle.
- R12: Read data appears on `rd_data` in the cycle after `rd_en`, and all unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register byte offset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe, ignored while wr_en is high |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |

## Verification
The hardest states to reach from the ports lie past the top of the array: a pointer of 0x200 or more, where pushes overflow and pops read wrapped cells. Filling all 512 cells through the data register takes a long run. The stimulus does this once in a directed pass, which also sets every cell to a known value. After that, random traffic often writes the pointer register with values near 0, near 0x200, and up to 0x3FF, so that overflow, underflow, wrapped indexing and the double-trigger case appear in every mode combination.

// File: rtl/byte_stack_regs.sv
module byte_stack_regs #(
  parameter int DEPTH_LOG2 = 9,
  parameter int DATA_W     = 8,
  parameter int BUS_W      = 32,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              rd_en,
  output logic [BUS_W-1:0]  rd_data
);
  localparam int PTR_W = DEPTH_LOG2 + 1;
  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  sp;
  logic              ovf, unf;
  logic [2:0]        cfg;
  logic [DATA_W-1:0] wsh, rsh;

  wire sel_data = addr[3:2] == 2'd0;
  wire sel_ctrl = addr[3:2] == 2'd1;
  wire sel_cfg  = addr[3:2] == 2'd2;
  wire sel_sp   = addr[3:2] == 2'd3;
  wire rd_ev    = rd_en && !wr_en;
  wire data_wr  = wr_en && sel_data;
  wire ctrl_wr  = wr_en && sel_ctrl;

  wire do_push = (data_wr && cfg[0]) || (ctrl_wr && wr_data[0]);
  wire do_pop  = (rd_ev && sel_data && cfg[1]) || (ctrl_wr && wr_data[1]);
  wire [DATA_W-1:0] push_val = data_wr ? wr_data[DATA_W-1:0] : wsh;

  wire             full    = sp >= PTR_W'(DEPTH);
  wire             empty   = sp == '0;
  wire             push_ok = do_push && !full;
  wire [PTR_W-1:0] sp_a    = sp + PTR_W'(push_ok);
  wire             pop_ok  = do_pop && (sp_a != '0);
  wire [PTR_W-1:0] sp_b    = sp_a - PTR_W'(pop_ok);
  wire [PTR_W-1:0] sp_m1   = sp - 1'b1;

  wire [DATA_W-1:0] below   = mem[sp_m1[DEPTH_LOG2-1:0]];
  wire [DATA_W-1:0] pop_val = push_ok ? push_val : mem[sp_b[DEPTH_LOG2-1:0]];

  logic [DATA_W-1:0] data_rd;
  always_comb begin
    if (cfg[1])                data_rd = pop_ok ? pop_val : rsh;
    else if (!cfg[2] || empty) data_rd = rsh;
    else                       data_rd = below;
  end

  logic [BUS_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (addr[3:2])
      2'd0: rd_mux[DATA_W-1:0] = data_rd;
      2'd1: rd_mux[7:4]        = {unf, ovf, full, empty};
      2'd2: rd_mux[2:0]        = cfg;
      2'd3: rd_mux[PTR_W-1:0]  = sp;
    endcase
  end

  always_ff @(posedge clk)
    if (push_ok) mem[sp[DEPTH_LOG2-1:0]] <= push_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp      <= '0;
      ovf     <= 1'b0;
      unf     <= 1'b0;
      cfg     <= '0;
      wsh     <= '0;
      rsh     <= '0;
      rd_data <= '0;
    end else begin
      sp <= (wr_en && sel_sp) ? wr_data[PTR_W-1:0] : sp_b;
      if (do_pop)       ovf <= 1'b0;
      else if (do_push && full) ovf <= 1'b1;
      if (do_pop && sp_a == '0) unf <= 1'b1;
      else if (do_push) unf <= 1'b0;
      if (wr_en && sel_cfg) cfg <= wr_data[2:0];
      if (data_wr) wsh <= wr_data[DATA_W-1:0];
      if (pop_ok)  rsh <= pop_val;
      if (rd_ev)   rd_data <= rd_mux;
    end
  end
endmodule

module byte_stack_chk #(
  parameter int PTR_W  = 10,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [BUS_W-1:0]  wr_data,
  input logic              rd_en,
  input logic [BUS_W-1:0]  rd_data,
  input logic [PTR_W-1:0]  sp,
  input logic              ovf,
  input logic              unf
);
  localparam logic [PTR_W-1:0] FULL_AT = PTR_W'(1 << (PTR_W - 1));

  // R4
  push_at_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr[3:2] == 2'd1 && wr_data[1:0] == 2'b01 && sp >= FULL_AT
    |=> ovf && $stable(sp));

  // R4
  push_clears_unf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr[3:2] == 2'd1 && wr_data[1:0] == 2'b01 |=> !unf);

  // R5
  pop_at_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr[3:2] == 2'd1 && wr_data[1:0] == 2'b10 && sp == '0
    |=> unf && sp == '0);

  // R5
  pop_clears_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr[3:2] == 2'd1 && wr_data[1] |=> !ovf);

  // R9
  ctrl_read_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && addr[3:2] == 2'd1
    |=> rd_data[3:0] == 4'd0 && rd_data[BUS_W-1:8] == '0);

  // R10
  sp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr[3:2] == 2'd3 |=> sp == $past(wr_data[PTR_W-1:0]));
endmodule

bind byte_stack_regs byte_stack_chk #(.PTR_W(PTR_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .sp(sp), .ovf(ovf), .unf(unf)
);

// File: tb/sim_byte_stack_regs.sv
module sim_byte_stack_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m [512];
  int         sp_m;
  bit         ovf_m, unf_m;
  bit [2:0]   cfg_m;
  logic [7:0] wsh_m, rsh_m;

  always #2 clk = ~clk;

  byte_stack_regs u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic m_push();
    if (sp_m >= 512) ovf_m = 1;
    else begin m[sp_m % 512] = wsh_m; sp_m++; end
    unf_m = 0;
  endtask

  task automatic m_pop();
    if (sp_m == 0) unf_m = 1;
    else begin sp_m--; rsh_m = m[sp_m % 512]; end
    ovf_m = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    case (a)
      4'h0: begin wsh_m = d[7:0]; if (cfg_m[0]) m_push(); end
      4'h4: begin if (d[0]) m_push(); if (d[1]) m_pop(); end
      4'h8: cfg_m = d[2:0];
      default: sp_m = int'(d[9:0]);
    endcase
  endtask

  task automatic rd(logic [3:0] a, string tag);
    logic [31:0] exp = '0;
    case (a)
      4'h0: begin
        if (cfg_m[1]) begin m_pop(); exp[7:0] = rsh_m; end
        else if (!cfg_m[2] || sp_m == 0) exp[7:0] = rsh_m;
        else exp[7:0] = m[(sp_m + 1023) % 512];
      end
      4'h4: exp[7:4] = {unf_m, ovf_m, sp_m >= 512, sp_m == 0};
      4'h8: exp[2:0] = cfg_m;
      default: exp[9:0] = 10'(sp_m);
    endcase
    @(negedge clk);
    addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    chk(tag, rd_data, exp);
  endtask

  task automatic rd_data_reg();
    if (cfg_m[1]) rd(4'h0, "R6");
    else if (cfg_m[2]) rd(4'h0, "R8");
    else rd(4'h0, "R7");
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    sp_m = 0; ovf_m = 0; unf_m = 0; cfg_m = 0; wsh_m = 0; rsh_m = 0;
    for (int i = 0; i < 512; i++) m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state, R12 unused bits
    rd(4'hC, "R1"); rd(4'h4, "R1"); rd(4'h8, "R1"); rd(4'h0, "R1");
    // R2 config readback, extra bits dropped
    wr(4'h8, 32'hFFFF_FFFF); rd(4'h8, "R2");
    // R3 manual push: data write alone does not push
    wr(4'h8, 32'h0); wr(4'h0, 32'h1234_56A5); rd(4'hC, "R3");
    wr(4'h4, 32'h1); rd(4'hC, "R3");
    // R8 read-then-pop sees cell below pointer
    wr(4'h8, 32'h4); rd(4'h0, "R8"); rd(4'hC, "R8");
    // R7 pop-then-read
    wr(4'h8, 32'h0); wr(4'h4, 32'h2); rd(4'h0, "R7"); rd(4'hC, "R7");
    // R5 underflow on empty pop, R9 status
    wr(4'h4, 32'h2); rd(4'h4, "R5"); rd(4'hC, "R5");
    // R3 auto push fill to full, R4 overflow
    wr(4'h8, 32'h3);
    for (int i = 0; i < 512; i++) wr(4'h0, 32'(8'(i * 37 + 11)));
    rd(4'h4, "R9"); rd(4'hC, "R4");
    wr(4'h0, 32'hEE); rd(4'h4, "R4"); rd(4'hC, "R4");
    // R6 auto pop clears overflow
    rd(4'h0, "R6"); rd(4'h4, "R6");
    // R11 both triggers
    wr(4'h0, 32'h5A); wr(4'h8, 32'h0); wr(4'h0, 32'hC3);
    wr(4'h4, 32'h3); rd(4'hC, "R11"); rd(4'h0, "R11"); rd(4'h4, "R11");
    // R10 wrap with large pointer
    wr(4'hC, 32'hFFFF_F3FF); rd(4'hC, "R10");
    wr(4'h8, 32'h4); rd(4'h0, "R10");
    wr(4'h4, 32'h3); rd(4'h0, "R10"); rd(4'h4, "R10");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int op = int'($urandom_range(0, 99));
      if (op < 25) wr(4'h0, $urandom);
      else if (op < 50) rd_data_reg();
      else if (op < 62) wr(4'h4, $urandom);
      else if (op < 68) wr(4'h8, $urandom);
      else if (op < 74) begin
        int k = int'($urandom_range(0, 3));
        logic [31:0] v = (k == 0) ? 32'($urandom_range(0, 2)) :
                         (k == 1) ? 32'($urandom_range(509, 515)) : $urandom;
        wr(4'hC, v);
      end
      else if (op < 86) rd(4'h4, "R9");
      else if (op < 92) rd(4'hC, "R10");
      else rd(4'h8, "R2");
    end
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule